// File: doc/BRIEF.md
# RAID-6 Dual Parity Generator

This block computes both check words of a RAID-6 stripe column from a stream of data words. Each word carries `LANES` independent bytes, one byte per lane. The block produces two results. P is the plain XOR of the matching bytes across all data disks. Q is the Reed-Solomon syndrome over GF(2^8) with generator 2, where each disk's byte is weighted by 2 raised to its disk index.

The data words arrive one disk at a time, starting with the highest-numbered data disk (index `NDISK-3`) and going down to disk 0. This order lets Q be built by Horner's rule: on each new word the running Q is doubled in the field and then XORed with the word. The doubling is a per-byte left shift, followed by an XOR with 0x1D when the byte's top bit was set. After exactly `NDISK-2` accepted words the P and Q pair is offered on a valid/ready output. The pair is held until the consumer takes it.

A sender may raise the first-word flag at any time to abandon a partial column and start a new one. The result slot can drain in the same cycle that the first word of the next column is accepted, so columns can stream with no idle cycle between them.

Top module: `pq_dual_parity`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and `out_p` and `out_q` are all zeros.
- R2: For a complete column, `out_p` equals the bytewise XOR of all `NDISK-2` data words.
- R3: Words are sent from disk index `NDISK-3` down to disk 0. For each byte lane, `out_q` equals the GF(2^8) sum over disks i of 2^i times that disk's byte, with field polynomial x^8+x^4+x^3+x^2+1.
- R4: Doubling a byte is a left shift by one. If bit 7 of the byte was 1, the shifted result is XORed with 0x1D. Every lane is processed independently of the others.
- R5: `out_valid` rises in the cycle after the `NDISK-2`-th accepted word, and not earlier.
- R6: While `out_valid` is 1 and `out_ready` is 0: `in_ready` is 0, and `out_p`, `out_q` and `out_valid` stay unchanged.
- R7: When a result is taken and no new word is accepted in that cycle, `out_valid` falls and `out_p` and `out_q` read zero in the next cycle.
- R8: A word accepted with `in_first` = 1 replaces both accumulators and restarts the word count at one, discarding any partial column.
- R9: `in_ready` is 1 whenever `out_ready` is 1. A word accepted in the same cycle a result is taken becomes the first word of the next column.
- R10: A cycle with `in_valid` = 0 changes neither the accumulators nor the word count, whatever `in_data` and `in_first` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Block can take a word |
| in_first | input | 1 | Word starts a new column |
| in_data | input | LANES*8 | Data word, lane k in bits 8k+7:8k |
| out_valid | output | 1 | P/Q result available |
| out_ready | input | 1 | Consumer takes the result |
| out_p | output | LANES*8 | XOR parity |
| out_q | output | LANES*8 | GF(2^8) syndrome |

## Verification
Two events can fall in the same cycle. One is the draining of a finished result. The other is the acceptance of the first word of the next column, which must load the accumulators instead of clearing them. The bench provokes this by holding `out_ready` high while offering two columns back to back with no gap. It checks that `in_ready` is high in the cycle where `out_valid` is high, and that both results match the reference sums.

// File: rtl/pq_pkg.sv
package pq_pkg;

    localparam logic [7:0] GF_POLY_LOW = 8'h1D;

    // Accumulator command issued by the controller each cycle
    typedef struct packed {
        logic load;   // replace accumulators with the word
        logic fold;   // accumulate the word
        logic clear;  // return accumulators to zero
    } acc_cmd_t;

    // Multiply one byte by the generator 2 in GF(2^8)
    function automatic logic [7:0] gf_dbl(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? GF_POLY_LOW : 8'h00);
    endfunction

endpackage

// File: rtl/pq_lane_fold.sv
module pq_lane_fold
    import pq_pkg::*;
(
    input  logic [7:0] q_cur,
    input  logic [7:0] d_byte,
    output logic [7:0] q_fold
);
    always_comb q_fold = gf_dbl(q_cur) ^ d_byte;
endmodule

// File: rtl/pq_acc.sv
module pq_acc
    import pq_pkg::*;
#(
    parameter int LANES = 16,
    localparam int DW = LANES * 8
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_cmd_t      cmd,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] p_acc,
    output logic [DW-1:0] q_acc
);
    logic [DW-1:0] q_next;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        pq_lane_fold u_fold (
            .q_cur (q_acc[8*k +: 8]),
            .d_byte(din[8*k +: 8]),
            .q_fold(q_next[8*k +: 8])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_acc <= '0;
            q_acc <= '0;
        end else if (cmd.load) begin
            p_acc <= din;
            q_acc <= din;
        end else if (cmd.fold) begin
            p_acc <= p_acc ^ din;
            q_acc <= q_next;
        end else if (cmd.clear) begin
            p_acc <= '0;
            q_acc <= '0;
        end
    end
endmodule

// File: rtl/pq_ctrl.sv
module pq_ctrl
    import pq_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int CW = $clog2(WORDS + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  logic     in_first,
    input  logic     out_ready,
    output logic     in_ready,
    output logic     out_valid,
    output acc_cmd_t cmd
);
    localparam logic [CW-1:0] LAST = CW'(WORDS);

    logic [CW-1:0] cnt, cnt_nxt;
    logic accept, drain, start, done;

    always_comb begin
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
        drain    = out_valid && out_ready;
        start    = in_first || (cnt == '0);
        cnt_nxt  = start ? CW'(1) : cnt + CW'(1);
        done     = accept && (cnt_nxt == LAST);
        cmd.load  = accept && start;
        cmd.fold  = accept && !start;
        cmd.clear = drain && !accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            out_valid <= 1'b0;
        end else begin
            if (accept) cnt <= done ? '0 : cnt_nxt;
            if (done) out_valid <= 1'b1;
            else if (drain) out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pq_dual_parity.sv
module pq_dual_parity
    import pq_pkg::*;
#(
    parameter int LANES = 16,
    parameter int NDISK = 6,
    localparam int DW = LANES * 8,
    localparam int WORDS = NDISK - 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_first,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_p,
    output logic [DW-1:0] out_q
);
    acc_cmd_t cmd;

    pq_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
        .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
        .cmd(cmd)
    );

    pq_acc #(.LANES(LANES)) u_acc (
        .clk(clk), .rst(rst), .cmd(cmd), .din(in_data),
        .p_acc(out_p), .q_acc(out_q)
    );
endmodule

// File: rtl/pq_dual_parity_chk.sv
module pq_dual_parity_chk #(
    parameter int DW = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_first,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_p,
    input logic [DW-1:0] out_q
);
    assert_rise_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    assert_hold_result_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_p) && $stable(out_q)));

    assert_stall_input_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_clear_after_drain_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !(in_valid && in_ready))
        |=> (!out_valid && out_p == '0 && out_q == '0));

    assert_first_no_result_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_first) |=> !out_valid);

    assert_ready_when_drain_R9: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);

    assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !out_valid) |=> ($stable(out_p) && $stable(out_q)));
endmodule

bind pq_dual_parity pq_dual_parity_chk #(.DW(LANES * 8)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .out_valid(out_valid), .out_ready(out_ready),
    .out_p(out_p), .out_q(out_q)
);

// File: tb/pq_dual_parity_tb.sv
`timescale 1ns/1ps
module pq_dual_parity_tb;
    localparam int LANES = 16;
    localparam int NDISK = 6;
    localparam int DW = LANES * 8;
    localparam int NDATA = NDISK - 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, out_valid;
    logic [DW-1:0] out_p, out_q;

    int n_checks = 0;
    int n_fail = 0;

    logic [DW-1:0] col [NDATA];
    logic [DW-1:0] exp_p, exp_q;

    always #4 clk = ~clk;

    pq_dual_parity #(.LANES(LANES), .NDISK(NDISK)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_first(in_first), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_p(out_p), .out_q(out_q)
    );

    function automatic logic [7:0] ref_dbl(input logic [7:0] b);
        logic [7:0] r;
        r = b << 1;
        if (b[7]) r = r ^ 8'h1D;
        return r;
    endfunction

    // Direct sum: P = xor D_i, Q = xor 2^i * D_i
    task automatic compute_ref();
        exp_p = '0;
        exp_q = '0;
        for (int i = 0; i < NDATA; i++) begin
            for (int k = 0; k < LANES; k++) begin
                logic [7:0] t;
                t = col[i][8*k +: 8];
                for (int j = 0; j < i; j++) t = ref_dbl(t);
                exp_p[8*k +: 8] = exp_p[8*k +: 8] ^ col[i][8*k +: 8];
                exp_q[8*k +: 8] = exp_q[8*k +: 8] ^ t;
            end
        end
    endtask

    task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] rnd_word();
        logic [DW-1:0] w;
        for (int k = 0; k < DW / 32; k++) w[32*k +: 32] = $urandom;
        return w;
    endfunction

    // Offer one word; it is accepted at the posedge after return
    task automatic send(input logic [DW-1:0] w, input logic first, input bit gap);
        if (gap) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_first = 1'b1;
            in_data  = rnd_word();
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_first = first;
        in_data  = w;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
    endtask

    task automatic send_column(input bit gaps);
        for (int i = NDATA - 1; i >= 0; i--)
            send(col[i], i == NDATA - 1, gaps && ($urandom % 2 == 1));
        idle();
    endtask

    task automatic take_and_compare(input string rp, input string rq);
        while (!out_valid) @(negedge clk);
        compute_ref();
        check(out_p == exp_p, rp, out_p, exp_p);
        check(out_q == exp_q, rq, out_q, exp_q);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        check(!out_valid && in_ready, "R1", {out_valid, in_ready}, 2'b01);
        check(out_p == '0 && out_q == '0, "R1", out_p | out_q, '0);
    endtask

    task automatic t_zero();
        for (int i = 0; i < NDATA; i++) col[i] = '0;
        send_column(1'b0);
        take_and_compare("R2 zero", "R3 zero");
    endtask

    task automatic t_topbit();
        logic [DW-1:0] e;
        for (int i = 0; i < NDATA; i++) col[i] = '0;
        col[1] = {LANES{8'h80}};
        send_column(1'b0);
        e = {LANES{8'h1D}};
        while (!out_valid) @(negedge clk);
        check(out_q == e, "R4 0x80*2", out_q, e);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        // mixed lanes: some with top bit set, some without
        for (int i = 0; i < NDATA; i++)
            for (int k = 0; k < LANES; k++)
                col[i][8*k +: 8] = (k % 2 == 1) ? (8'h80 | 8'(k + 7*i)) : 8'(k + 3*i);
        send_column(1'b0);
        take_and_compare("R2 topbit", "R4 lanes");
    endtask

    task automatic t_random();
        for (int n = 0; n < 6; n++) begin
            for (int i = 0; i < NDATA; i++) col[i] = rnd_word();
            send_column(1'b1);
            take_and_compare("R2 random", "R3 random");
        end
    endtask

    task automatic t_timing();
        for (int i = 0; i < NDATA; i++) col[i] = rnd_word();
        for (int i = NDATA - 1; i >= 0; i--) begin
            send(col[i], i == NDATA - 1, 1'b0);
            idle();
            check(out_valid == (i == 0), "R5 valid timing", DW'(out_valid), DW'(i == 0));
        end
        take_and_compare("R2 timing", "R3 timing");
    endtask

    task automatic t_hold();
        logic [DW-1:0] hp, hq;
        for (int i = 0; i < NDATA; i++) col[i] = rnd_word();
        send_column(1'b0);
        while (!out_valid) @(negedge clk);
        hp = out_p;
        hq = out_q;
        for (int n = 0; n < 4; n++) begin
            in_valid = 1'b1;
            in_first = 1'b1;
            in_data  = rnd_word();
            @(negedge clk);
            check(!in_ready && out_valid, "R6 stall", DW'({in_ready, out_valid}), DW'(2'b01));
            check(out_p == hp && out_q == hq, "R6 hold", out_p ^ out_q, hp ^ hq);
        end
        in_valid = 1'b0;
        take_and_compare("R6 P kept", "R6 Q kept");
        check(out_p == '0 && out_q == '0 && !out_valid, "R7 cleared", out_p | out_q, '0);
    endtask

    task automatic t_restart();
        send(rnd_word(), 1'b1, 1'b0);
        send(rnd_word(), 1'b0, 1'b0);
        for (int i = 0; i < NDATA; i++) col[i] = rnd_word();
        send_column(1'b0);
        take_and_compare("R8 P restart", "R8 Q restart");
    endtask

    task automatic t_back_to_back();
        logic [DW-1:0] colb [NDATA];
        logic [DW-1:0] got_p [2];
        logic [DW-1:0] got_q [2];
        int got;
        bit ready_seen;
        got = 0;
        ready_seen = 1'b1;
        for (int i = 0; i < NDATA; i++) begin
            col[i]  = rnd_word();
            colb[i] = rnd_word();
        end
        @(negedge clk);
        out_ready = 1'b1;
        fork
            begin
                for (int i = NDATA - 1; i >= 0; i--) send(col[i], i == NDATA - 1, 1'b0);
                for (int i = NDATA - 1; i >= 0; i--) send(colb[i], 1'b0, 1'b0);
                idle();
            end
            begin
                for (int c = 0; c < 8 * NDATA && got < 2; c++) begin
                    @(negedge clk);
                    if (out_valid) begin
                        if (!in_ready) ready_seen = 1'b0;
                        got_p[got] = out_p;
                        got_q[got] = out_q;
                        got++;
                    end
                end
            end
        join
        out_ready = 1'b0;
        check(got == 2, "R9 two results", DW'(got), DW'(2));
        check(ready_seen, "R9 ready on drain", DW'(ready_seen), DW'(1));
        compute_ref();
        check(got_p[0] == exp_p && got_q[0] == exp_q, "R9 first column", got_q[0], exp_q);
        for (int i = 0; i < NDATA; i++) col[i] = colb[i];
        compute_ref();
        check(got_p[1] == exp_p && got_q[1] == exp_q, "R9 second column", got_q[1], exp_q);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero();
        t_topbit();
        t_random();
        t_timing();
        t_hold();
        t_restart();
        t_back_to_back();
        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule